// File: doc/BRIEF.md
# Triggered Capture Ring with Block Timestamps

This block stores a stream of wide sample words into an on-chip circular buffer, but only after a trigger arrives. A trigger opens a capture window of a fixed number of words. A trigger that arrives while a window is still open stretches that window instead of restarting it. A free-running cycle counter is copied into a small side memory each time the write pointer crosses into a new block of the buffer. A reader can later use these copies to place each block in time.

Both memories are written on one clock edge and read through a registered port. This lets synthesis map them onto block RAM. A downstream consumer reads words and timestamps by address and gets the data one cycle later. The consumer also watches the live write position to learn how far capture has advanced.

The default size is 8 blocks of 256 words, which gives 2048 entries. The window is 3 blocks long, which is 768 words. Block size, block count, window length and word widths are all parameters.

Top module: `capture_ring`

## Requirements
- R1: While `rst_n` is low, the write pointer, the remaining-word counter and the time counter are all zero. After reset, no word is written until a trigger arrives.
- R2: A trigger while idle causes exactly WINDOW words to be written, one per cycle, on the WINDOW cycles after the trigger cycle. Each word goes to the current `wr_ptr_o` address, and `wr_ptr_o` then advances by one.
- R3: With no window open and no trigger, `wr_ptr_o` holds its value and no memory contents change.
- R4: A trigger in a cycle where r words remain still writes that cycle's word. The remaining count then becomes (r mod BLOCK) + WINDOW.
- R5: `rd_data_o` shows, one cycle after `rd_addr_i` is applied, the word most recently written at that address before the sampling edge. A write on the same edge does not yet show.
- R6: A word written at a pointer whose low log2(BLOCK) bits are zero also writes the time counter's current value into timestamp entry `wr_ptr_o >> log2(BLOCK)`.
- R7: The time counter is 0 in the first clock cycle after reset and advances by one on every cycle, whether or not capture is active.
- R8: The write pointer wraps from DEPTH-1 to 0, and the timestamp index therefore wraps from NBLK-1 to 0.
- R9: `ts_rd_data_o` shows the timestamp entry at `ts_rd_idx_i` one cycle after the index is applied, with read-before-write on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_i | input | DW (64) | Sample word offered every cycle |
| trig_i | input | 1 | Trigger pulse, one cycle per event |
| rd_addr_i | input | AW (11) | Data buffer read address |
| rd_data_o | output | DW (64) | Registered data buffer read word |
| ts_rd_idx_i | input | NBLK_LOG2 (3) | Timestamp read index |
| ts_rd_data_o | output | TW (32) | Registered timestamp read word |
| wr_ptr_o | output | AW (11) | Address the next captured word goes to |

## Verification
A wrong remaining-word count shows at `wr_ptr_o` as soon as a window closes. The pointer keeps running or stops early, and the final position is off by the size of the error. A retrigger that mishandles the modulo step leaves the pointer off by a multiple of a block after the stretched window ends. A time counter that stalls, or a timestamp written at the wrong index, stays hidden until that entry is read back. The bench therefore reads timestamp entries every cycle and compares them with the cycle count at which each block began. A pointer that skips or repeats an address shows on the next read of a data word near the write front.

// File: rtl/capture_ring.sv
module capture_ring #(
  parameter int DW            = 64,
  parameter int TW            = 32,
  parameter int BLOCK_LOG2    = 8,
  parameter int NBLK_LOG2     = 3,
  parameter int WINDOW_BLOCKS = 3,
  localparam int AW     = BLOCK_LOG2 + NBLK_LOG2,
  localparam int DEPTH  = 1 << AW,
  localparam int NBLK   = 1 << NBLK_LOG2,
  localparam int BLOCK  = 1 << BLOCK_LOG2,
  localparam int WINDOW = WINDOW_BLOCKS * BLOCK,
  localparam int CW     = $clog2(WINDOW + BLOCK)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DW-1:0]        sample_i,
  input  logic                 trig_i,
  input  logic [AW-1:0]        rd_addr_i,
  output logic [DW-1:0]        rd_data_o,
  input  logic [NBLK_LOG2-1:0] ts_rd_idx_i,
  output logic [TW-1:0]        ts_rd_data_o,
  output logic [AW-1:0]        wr_ptr_o
);

  logic [CW-1:0] remain;
  logic [AW-1:0] wptr;
  logic [TW-1:0] tnow;
  logic [DW-1:0] mem [DEPTH];
  logic [TW-1:0] ts_mem [NBLK];

  wire active    = remain != '0;
  wire blk_start = wptr[BLOCK_LOG2-1:0] == '0;
  wire [CW-1:0] extended = CW'(remain[BLOCK_LOG2-1:0]) + CW'(WINDOW);

  assign wr_ptr_o = wptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      wptr   <= '0;
      tnow   <= '0;
    end else begin
      tnow <= tnow + 1'b1;
      if (active) wptr <= wptr + 1'b1;
      if (trig_i)      remain <= extended;
      else if (active) remain <= remain - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (active) mem[wptr] <= sample_i;
    rd_data_o <= mem[rd_addr_i];
  end

  always_ff @(posedge clk) begin
    if (active && blk_start) ts_mem[wptr[AW-1:BLOCK_LOG2]] <= tnow;
    ts_rd_data_o <= ts_mem[ts_rd_idx_i];
  end

endmodule

// File: rtl/capture_ring_chk.sv
module capture_ring_chk #(
  parameter int AW         = 11,
  parameter int CW         = 10,
  parameter int BLOCK      = 256,
  parameter int WINDOW     = 768
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trig_i,
  input logic [AW-1:0] wr_ptr_o,
  input logic [CW-1:0] remain
);

  assert_ptr_advances_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (remain != '0) |=> (wr_ptr_o == $past(wr_ptr_o) + 1'b1));

  assert_ptr_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (remain == '0) |=> $stable(wr_ptr_o));

  assert_idle_stays_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (remain == '0 && !trig_i) |=> (remain == '0));

  assert_window_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> (int'(remain) >= WINDOW && int'(remain) < WINDOW + BLOCK));

  assert_ptr_wraps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (remain != '0 && wr_ptr_o == '1) |=> (wr_ptr_o == '0));

endmodule

bind capture_ring capture_ring_chk #(
  .AW(AW), .CW(CW), .BLOCK(BLOCK), .WINDOW(WINDOW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .wr_ptr_o(wr_ptr_o), .remain(remain)
);

// File: tb/capture_ring_tb.sv
module capture_ring_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 64, TW = 32, BL2 = 8, NL2 = 3;
  localparam int BLOCK = 1 << BL2, NBLK = 1 << NL2;
  localparam int DEPTH = BLOCK * NBLK, WINDOW = 3 * BLOCK;
  localparam int AW = BL2 + NL2;

  logic clk = 0, rst_n = 0, trig = 0;
  logic [DW-1:0] sample = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [NL2-1:0] ts_idx = '0;
  logic [DW-1:0] rd_data;
  logic [TW-1:0] ts_data;
  logic [AW-1:0] wr_ptr;

  capture_ring u_dut (.clk(clk), .rst_n(rst_n), .sample_i(sample), .trig_i(trig),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .ts_rd_idx_i(ts_idx),
    .ts_rd_data_o(ts_data), .wr_ptr_o(wr_ptr));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  logic [DW-1:0] m_mem [DEPTH];
  bit            m_val [DEPTH];
  logic [TW-1:0] m_ts  [NBLK];
  bit            m_tsv [NBLK];
  int m_rem = 0, m_ptr = 0;
  longint m_time = 0;
  logic [DW-1:0] e_rd;  bit e_rd_v = 0;
  logic [TW-1:0] e_ts;  bit e_ts_v = 0;

  initial begin
    for (int i = 0; i < DEPTH; i++) m_val[i] = 0;
    for (int i = 0; i < NBLK; i++) m_tsv[i] = 0;
  end

  always @(posedge clk) begin
    cycles++;
    e_rd_v = rst_n && m_val[rd_addr];
    e_rd   = m_mem[rd_addr];
    e_ts_v = rst_n && m_tsv[ts_idx];
    e_ts   = m_ts[ts_idx];
    if (!rst_n) begin
      m_rem = 0; m_ptr = 0; m_time = 0;
    end else begin
      int nrem;
      if (m_rem > 0) begin
        m_mem[m_ptr] = sample; m_val[m_ptr] = 1;
        if (m_ptr % BLOCK == 0) begin
          m_ts[m_ptr / BLOCK] = TW'(m_time); m_tsv[m_ptr / BLOCK] = 1;
        end
        m_ptr = (m_ptr + 1) % DEPTH;
      end
      if (trig) nrem = (m_rem % BLOCK) + WINDOW;
      else nrem = (m_rem > 0) ? m_rem - 1 : 0;
      m_rem = nrem;
      m_time++;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the reference model
  always @(negedge clk) if (rst_n && !done) begin
    check(int'(wr_ptr) == m_ptr, "R2/R3/R4/R8 wr_ptr", wr_ptr, m_ptr);
    if (e_rd_v) check(rd_data === e_rd, "R5 rd_data", rd_data, e_rd);
    if (e_ts_v) check(ts_data === e_ts, "R6/R7/R9 ts_data", ts_data, e_ts);
  end

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) if (cycles > 150000 && !done) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    finish_run();
  end

  task automatic step(input bit t);
    @(negedge clk);
    trig    = t;
    sample  = {$urandom, $urandom};
    rd_addr = AW'(m_ptr - 1 - ($urandom % 4));
    ts_idx  = NL2'($urandom);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(wr_ptr == '0, "R1 reset ptr", wr_ptr, 0);
    rst_n = 1;
    repeat (50) step(0);
    check(wr_ptr == '0, "R3 idle ptr", wr_ptr, 0);
    step(1);
    repeat (WINDOW + 20) step(0);
    @(negedge clk);
    check(int'(wr_ptr) == WINDOW, "R2 window length", wr_ptr, WINDOW);
    step(1);
    repeat (300) step(0);
    step(1);
    repeat (2000) step(0);
    @(negedge clk);
    check(int'(wr_ptr) == (WINDOW + 301 + (WINDOW - 300) % BLOCK + WINDOW) % DEPTH,
          "R4 retrigger extend", wr_ptr, (WINDOW + 301 + (WINDOW - 300) % BLOCK + WINDOW) % DEPTH);
    for (int i = 0; i < 12000; i++) step(($urandom % 400) == 0);
    for (int i = 0; i < 40; i++) step(1);
    repeat (1500) step(0);
    rst_n = 0;
    @(negedge clk);
    check(wr_ptr == '0, "R1 mid-run reset", wr_ptr, 0);
    rst_n = 1;
    step(1);
    repeat (WINDOW * 4) step(($urandom % 300) == 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule